// File: doc/BRIEF.md
# Per-Face Bloom Filter Forwarding Lookup

This block is the forwarding table of a content-centric router. Every output face owns a private Bloom filter. A caller presents a 32-bit hash of a name prefix together with a command. A lookup probes the filters of all faces in parallel and returns a vector with one bit per face. A bit is set when that face's filter may hold the prefix. An insert marks the prefix in one chosen face's filter. A clear empties one chosen filter.

Three probe indices are derived from the hash. Each index is a 10-bit slice of the hash XORed with a fixed salt. A face bit reports a match only when all three probed bits of that face are set. Single prefixes cannot be removed, so the only way to forget state is to clear a whole filter. A clear walks the filter one 32-bit word per cycle. While it runs, the block raises a busy flag and ignores every command.

Bloom filters can give false positives. As a result, a request may be forwarded to faces that never registered the prefix. Callers must accept this.

Top module: `bloom_fwd_lookup`

## Requirements
- R1: Probe index k is formed as hash[10k+9:10k] XOR a salt, with salts 0x155, 0x2A3 and 0x0F6 for k = 0, 1, 2. Hash bits 31:30 are additionally XORed into bits 1:0 of index 2, so those two bits change the result.
- R2: A lookup accepted at a clock edge makes `rsp_valid` high for exactly the following cycle. Bit f of `rsp_faces` belongs to face f and is set only when all three probed bits of face f are set. In cycles without a response, `rsp_faces` is zero.
- R3: An insert sets the three probed bits of the face named by `cmd_face` in one cycle. The filters of the other faces do not change.
- R4: A lookup accepted in the cycle directly after an insert already sees that insert.
- R5: A hash that was never inserted still hits a face when its three indices all land on bits that other inserts set (false positive).
- R6: A face with only two of the three probed bits set reports no match.
- R7: An accepted clear (`cmd_op` 3) raises `busy` for exactly 32 cycles, one per 32-bit word. At the end the selected face's filter is empty, and the other faces keep their contents.
- R8: While `busy` is high, every command is ignored: a lookup gives no response and an insert leaves the filters unchanged.
- R9: Synchronous reset empties all filters and drives `busy`, `rsp_valid` and `rsp_faces` low.
- R10: A prefix inserted into several faces makes the lookup report all of those faces at once.
- R11: Command encodings are 0 idle, 1 lookup, 2 insert and 3 clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | Command code: 0 idle, 1 lookup, 2 insert, 3 clear |
| cmd_face | input | 2 | Target face for insert and clear |
| cmd_hash | input | 32 | Name-prefix hash for lookup and insert |
| busy | output | 1 | A filter clear is in progress; commands are refused |
| rsp_valid | output | 1 | Lookup result is valid this cycle |
| rsp_faces | output | 4 | One bit per face that may hold the prefix |

## Verification
The bench issues a lookup directly behind an insert. A design that registers the write path one cycle late would miss that lookup.

It builds a false positive from the bits of two other prefixes. It also probes a hash that matches only two of the three bits; a design that ORs the probes instead of ANDing them would wrongly report a hit.

During a clear, it sends a lookup and an insert. A design that does not gate commands with `busy` would either answer the lookup or corrupt another face. The bench also counts the busy cycles, which catches an off-by-one in the word sequencer.

Finally, two hashes that differ only in bits 31:30 show whether those bits reach the third index.

// File: rtl/fwd_bloom_pkg.sv
package fwd_bloom_pkg;

    localparam int FACES     = 4;
    localparam int FILT_BITS = 1024;
    localparam int PROBES    = 3;
    localparam int HASH_W    = 32;
    localparam int WORD_W    = 32;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'd0,
        OP_LOOKUP = 2'd1,
        OP_INSERT = 2'd2,
        OP_CLEAR  = 2'd3
    } fwd_op_e;

    typedef struct packed {
        logic lookup;
        logic insert;
        logic clear;
    } cmd_dec_t;

    // Fixed salt applied to probe index k
    function automatic logic [15:0] probe_salt(input int k);
        case (k % 3)
            0:       return 16'h0155;
            1:       return 16'h02A3;
            default: return 16'h00F6;
        endcase
    endfunction

    function automatic cmd_dec_t decode_cmd(input logic vld, input fwd_op_e op);
        cmd_dec_t d;
        d.lookup = vld && (op == OP_LOOKUP);
        d.insert = vld && (op == OP_INSERT);
        d.clear  = vld && (op == OP_CLEAR);
        return d;
    endfunction

endpackage

// File: rtl/bloom_probe_gen.sv
module bloom_probe_gen
    import fwd_bloom_pkg::*;
#(
    parameter int HASH_BITS = 32,
    parameter int IDX_W     = 10,
    parameter int NPROBES   = 3
) (
    input  logic [HASH_BITS-1:0]            hash,
    output logic [NPROBES-1:0][IDX_W-1:0]   idx
);
    localparam int SPARE = HASH_BITS - NPROBES * IDX_W;

    logic [IDX_W-1:0] fold;

    generate
        if (SPARE > 0) begin : g_fold
            assign fold = IDX_W'(hash[HASH_BITS-1 -: SPARE]);
        end else begin : g_nofold
            assign fold = '0;
        end
    endgenerate

    always_comb begin
        for (int k = 0; k < NPROBES; k++) begin
            idx[k] = hash[k*IDX_W +: IDX_W] ^ IDX_W'(probe_salt(k));
            if (k == NPROBES - 1) begin
                idx[k] = idx[k] ^ fold;
            end
        end
    end

    initial begin
        // R1
        probe_width_chk: assert (SPARE >= 0 && SPARE <= IDX_W)
            else $error("hash width does not fit probe slicing");
    end

endmodule

// File: rtl/bloom_face_filter.sv
module bloom_face_filter #(
    parameter int FBITS   = 1024,
    parameter int IDX_W   = 10,
    parameter int NPROBES = 3,
    parameter int WBITS   = 32,
    parameter int NWORDS  = FBITS / WBITS,
    parameter int WCNT_W  = $clog2(NWORDS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           ins_en,
    input  logic                           clr_en,
    input  logic [WCNT_W-1:0]              clr_word,
    input  logic [NPROBES-1:0][IDX_W-1:0]  idx,
    output logic                           hit
);
    logic [FBITS-1:0] bits_q;
    logic [NWORDS-1:0][WBITS-1:0] words_v;

    assign words_v = bits_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            bits_q <= '0;
        end else begin
            if (clr_en) begin
                bits_q[clr_word*WBITS +: WBITS] <= '0;
            end
            if (ins_en) begin
                for (int k = 0; k < NPROBES; k++) begin
                    bits_q[idx[k]] <= 1'b1;
                end
            end
        end
    end

    always_comb begin
        hit = 1'b1;
        for (int k = 0; k < NPROBES; k++) begin
            hit = hit & bits_q[idx[k]];
        end
    end

    generate
        for (genvar k = 0; k < NPROBES; k++) begin : g_ins_chk
            // R3
            probe_set_chk: assert property (@(posedge clk) disable iff (rst)
                ins_en |=> bits_q[$past(idx[k])]);
        end
    endgenerate

    // R7
    word_zero_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_en && !ins_en) |=> (words_v[$past(clr_word)] == '0));

    // R8
    no_loss_chk: assert property (@(posedge clk) disable iff (rst)
        !clr_en |=> (($past(bits_q) & ~bits_q) == '0));

endmodule

// File: rtl/bloom_clear_seq.sv
module bloom_clear_seq #(
    parameter int NWORDS = 32,
    parameter int FACE_W = 2,
    parameter int WCNT_W = $clog2(NWORDS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [FACE_W-1:0] start_face,
    output logic              busy,
    output logic [WCNT_W-1:0] word,
    output logic [FACE_W-1:0] face
);
    localparam logic [WCNT_W-1:0] LAST = WCNT_W'(NWORDS - 1);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            word <= '0;
            face <= '0;
        end else if (!busy) begin
            if (start) begin
                busy <= 1'b1;
                word <= '0;
                face <= start_face;
            end
        end else begin
            if (word == LAST) begin
                busy <= 1'b0;
                word <= '0;
            end else begin
                word <= word + 1'b1;
            end
        end
    end

    // R7
    clear_start_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && word == '0));

    // R7
    clear_end_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> ($past(word) == LAST));

    // R8
    face_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(face));

endmodule

// File: rtl/bloom_fwd_lookup.sv
module bloom_fwd_lookup
    import fwd_bloom_pkg::*;
#(
    parameter int NUM_FACES   = FACES,
    parameter int FILTER_BITS = FILT_BITS,
    parameter int NUM_PROBES  = PROBES,
    parameter int HASH_BITS   = HASH_W,
    parameter int WORD_BITS   = WORD_W,
    localparam int FACE_W     = $clog2(NUM_FACES),
    localparam int IDX_W      = $clog2(FILTER_BITS),
    localparam int NWORDS     = FILTER_BITS / WORD_BITS,
    localparam int WCNT_W     = $clog2(NWORDS)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cmd_valid,
    input  logic [1:0]            cmd_op,
    input  logic [FACE_W-1:0]     cmd_face,
    input  logic [HASH_BITS-1:0]  cmd_hash,
    output logic                  busy,
    output logic                  rsp_valid,
    output logic [NUM_FACES-1:0]  rsp_faces
);
    cmd_dec_t                          dec;
    logic [NUM_PROBES-1:0][IDX_W-1:0]  idx;
    logic [NUM_FACES-1:0]              hit;
    logic [NUM_FACES-1:0]              ins_vec;
    logic [NUM_FACES-1:0]              clr_vec;
    logic [WCNT_W-1:0]                 clr_word;
    logic [FACE_W-1:0]                 clr_face;

    // Commands are only seen while no clear is running
    assign dec = decode_cmd(cmd_valid && !busy, fwd_op_e'(cmd_op));

    bloom_probe_gen #(
        .HASH_BITS (HASH_BITS),
        .IDX_W     (IDX_W),
        .NPROBES   (NUM_PROBES)
    ) u_probe (
        .hash (cmd_hash),
        .idx  (idx)
    );

    bloom_clear_seq #(
        .NWORDS (NWORDS),
        .FACE_W (FACE_W)
    ) u_clr (
        .clk        (clk),
        .rst        (rst),
        .start      (dec.clear),
        .start_face (cmd_face),
        .busy       (busy),
        .word       (clr_word),
        .face       (clr_face)
    );

    generate
        for (genvar f = 0; f < NUM_FACES; f++) begin : g_face
            assign ins_vec[f] = dec.insert && (cmd_face == FACE_W'(f));
            assign clr_vec[f] = busy && (clr_face == FACE_W'(f));

            bloom_face_filter #(
                .FBITS   (FILTER_BITS),
                .IDX_W   (IDX_W),
                .NPROBES (NUM_PROBES),
                .WBITS   (WORD_BITS)
            ) u_filt (
                .clk      (clk),
                .rst      (rst),
                .ins_en   (ins_vec[f]),
                .clr_en   (clr_vec[f]),
                .clr_word (clr_word),
                .idx      (idx),
                .hit      (hit[f])
            );
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_faces <= '0;
        end else begin
            rsp_valid <= dec.lookup;
            rsp_faces <= dec.lookup ? hit : '0;
        end
    end

    // R2
    rsp_source_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_valid |-> $past(cmd_valid && cmd_op == 2'd1 && !busy));

    // R8
    busy_refuse_chk: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd_valid) |=> !rsp_valid);

    // R3
    ins_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(ins_vec));

    // R8
    no_cmd_while_busy_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (ins_vec == '0));

endmodule

// File: tb/sim_bloom_fwd_lookup.sv
`timescale 1ns/1ps
module sim_bloom_fwd_lookup;

    logic       clk = 1'b0;
    logic       rst;
    logic       cmd_valid;
    logic [1:0] cmd_op;
    logic [1:0] cmd_face;
    logic [31:0] cmd_hash;
    logic       busy;
    logic       rsp_valid;
    logic [3:0] rsp_faces;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bloom_fwd_lookup u0 (
        .clk       (clk),
        .rst       (rst),
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .cmd_face  (cmd_face),
        .cmd_hash  (cmd_hash),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_faces (rsp_faces)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [1:0]  face;
        logic [31:0] hash;
        logic        exp_v;
        logic [3:0]  exp_f;
    } vec_t;

    localparam int NV = 14;
    localparam vec_t VECS [NV] = '{
        '{2'd1, 2'd0, 32'h0000_0000, 1'b1, 4'b0000}, // R9 empty after reset
        '{2'd2, 2'd0, 32'h0000_0000, 1'b0, 4'b0000}, // R3 insert A face0
        '{2'd1, 2'd0, 32'h0000_0000, 1'b1, 4'b0001}, // R4 back-to-back, R3 face0 only
        '{2'd2, 2'd2, 32'h0000_0000, 1'b0, 4'b0000}, // R11 insert code
        '{2'd1, 2'd0, 32'h0000_0000, 1'b1, 4'b0101}, // R10 two faces
        '{2'd1, 2'd0, 32'h0010_0000, 1'b1, 4'b0000}, // R6 two of three bits
        '{2'd2, 2'd1, 32'h0010_0401, 1'b0, 4'b0000}, // insert B face1
        '{2'd2, 2'd1, 32'h0000_0000, 1'b0, 4'b0000}, // insert A face1
        '{2'd1, 2'd0, 32'h0000_0400, 1'b1, 4'b0010}, // R5 false positive
        '{2'd1, 2'd0, 32'h0010_0401, 1'b1, 4'b0010}, // R2 hit B
        '{2'd2, 2'd3, 32'hFFFF_FFFF, 1'b0, 4'b0000}, // insert face3
        '{2'd1, 2'd0, 32'hFFFF_FFFF, 1'b1, 4'b1000}, // R1 slice and salt
        '{2'd1, 2'd0, 32'h3FFF_FFFF, 1'b1, 4'b0000}, // R1 top bits fold
        '{2'd0, 2'd0, 32'h0000_0000, 1'b0, 4'b0000}  // R11 idle code
    };

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [1:0] op, input logic [1:0] face, input logic [31:0] h);
        cmd_valid = v;
        cmd_op    = op;
        cmd_face  = face;
        cmd_hash  = h;
    endtask

    task automatic lookup_expect(input logic [31:0] h, input logic [3:0] exp, input string req);
        drive(1'b1, 2'd1, 2'd0, h);
        @(negedge clk);
        drive(1'b0, 2'd0, 2'd0, 32'h0);
        check(rsp_valid === 1'b1 && rsp_faces === exp, req,
              {27'd0, rsp_valid, rsp_faces}, {27'd0, 1'b1, exp});
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int cyc;
        rst = 1'b1;
        drive(1'b0, 2'd0, 2'd0, 32'h0);
        repeat (3) @(negedge clk);
        // R9 reset state
        check(busy === 1'b0 && rsp_valid === 1'b0 && rsp_faces === 4'b0, "R9 reset outputs",
              {27'd0, busy, rsp_valid, rsp_faces}, 32'd0);
        rst = 1'b0;

        // Vector table, one command per cycle
        for (int i = 0; i < NV; i++) begin
            drive(1'b1, VECS[i].op, VECS[i].face, VECS[i].hash);
            @(negedge clk);
            check(rsp_valid === VECS[i].exp_v && rsp_faces === VECS[i].exp_f,
                  $sformatf("R2 vector %0d", i),
                  {27'd0, rsp_valid, rsp_faces}, {27'd0, VECS[i].exp_v, VECS[i].exp_f});
        end
        drive(1'b0, 2'd0, 2'd0, 32'h0);
        @(negedge clk);

        // R7 clear face1, R8 commands refused during the clear
        drive(1'b1, 2'd3, 2'd1, 32'h0);
        cyc = 0;
        for (int k = 0; k < 40; k++) begin
            @(negedge clk);
            if (busy) cyc++;
            if (k == 0) begin
                drive(1'b1, 2'd1, 2'd0, 32'h0000_0000);
            end else if (k == 1) begin
                check(rsp_valid === 1'b0, "R8 lookup refused while busy",
                      {31'd0, rsp_valid}, 32'd0);
                drive(1'b1, 2'd2, 2'd3, 32'h0000_0000);
            end else if (k == 2) begin
                drive(1'b0, 2'd0, 2'd0, 32'h0);
            end
        end
        check(cyc == 32, "R7 busy cycle count", cyc, 32);
        check(busy === 1'b0, "R7 busy released", {31'd0, busy}, 32'd0);

        lookup_expect(32'h0000_0000, 4'b0101, "R7 R8 A after clear face1");
        lookup_expect(32'h0010_0401, 4'b0000, "R7 B gone from face1");
        lookup_expect(32'hFFFF_FFFF, 4'b1000, "R7 face3 kept");

        // R9 reset in mid-run empties filters
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        check(busy === 1'b0 && rsp_valid === 1'b0, "R9 outputs after reset",
              {30'd0, busy, rsp_valid}, 32'd0);
        lookup_expect(32'h0000_0000, 4'b0000, "R9 filters empty after reset");
        @(negedge clk);
        check(rsp_valid === 1'b0 && rsp_faces === 4'b0, "R2 single-cycle response",
              {27'd0, rsp_valid, rsp_faces}, 32'd0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule